// File: doc/BRIEF.md
# SMBus Transaction Sequencer

This block is the command engine of an SMBus host that is driven through a small register file. Software loads a target address, a command byte, up to 32 data bytes and a byte count, then writes a protocol code. That single write launches a complete bus transaction: quick, send/receive byte, byte or word data, block data, process call, block process call, or a raw I2C block transfer.

The block does not drive SCL or SDA itself. It breaks each transaction into an ordered list of byte-level operations (start, stop, byte write, byte read with a chosen acknowledge) and hands them one at a time to an external bit-level engine over a request/response handshake. An operation is held steady on `op_*` until `rsp_valid` returns its result. When the transaction ends, the status register reports a done flag and a five-bit completion code. Optional packet error checking appends or verifies a CRC-8.

Top module: `smbus_seq`

## Requirements
- R1: After reset every register reads 0 and `op_valid` is low.
- R2: Writing the protocol register (offset 0x00) while idle starts a transaction. The first operation is START. The first address byte is the address register (offset 0x02) with bit 0 replaced by the direction bit.
- R3: Operation codes on `op_code` are 0 START, 1 STOP, 2 WRITE (byte on `op_data`) and 3 READ (`op_data` is 0). Each form issues its operations in SMBus order, and every transaction ends with STOP.
- R4: Protocol bit 0 selects read (1) or write (0). Protocol bits 6:1 select the form: 0x01 quick, 0x02 byte, 0x03 byte-data, 0x04 word, 0x05 block, 0x06 process call (bit 0 = 0) or block process call (bit 0 = 1), 0x25 I2C block. A word uses data offset 0 (register 0x04) for the low byte and offset 1 for the high byte. A process call writes a word and then reads a word back after a repeated start.
- R5: A block write sends a count byte equal to the block-count register (0x24) capped at 32, then that many data bytes. The write half of a block process call caps the count at 31.
- R6: On a block read, the count byte received from the target is stored in register 0x24. The sequencer then reads min(count, 32) data bytes into the data registers from offset 0.
- R7: The I2C block form takes its length from register 0x24 (capped at 32) in both directions, and no count byte appears on the bus.
- R8: Every byte read is acknowledged (`op_nack` = 0) except the final byte of the transaction, which carries `op_nack` = 1. A received count byte is always acknowledged.
- R9: Protocol bit 7 requests packet error checking for every form except quick. The check is a CRC-8 with polynomial 0x07 and initial value 0, covering every address, command, count and data byte. A write transaction appends the CRC. A read transaction reads one more byte, and a mismatch ends with code 0x1F.
- R10: A NACK on either address byte ends the transaction with STOP and code 0x10. A NACK on any other written byte ends it with STOP and code 0x11.
- R11: A protocol code with an unlisted form finishes at once with code 0x19 and issues no bus operation.
- R12: A protocol-register write while a transaction is running is ignored.
- R13: The status register (0x01) has the done flag in bit 7, which is cleared when a transaction starts and set when it finishes. Bits 4:0 hold the completion code (0x00 ok), and bits 6:5 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | AW (6) | Register offset for reads and writes |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational on `reg_addr`) |
| op_valid | output | 1 | A byte-level operation is requested |
| op_code | output | 2 | Operation: 0 start, 1 stop, 2 write, 3 read |
| op_data | output | 8 | Byte to send for a write operation |
| op_nack | output | 1 | For a read: answer the byte with NACK |
| rsp_valid | input | 1 | Engine finished the current operation |
| rsp_data | input | 8 | Byte received by a read operation |
| rsp_nack | input | 1 | Target did not acknowledge a written byte |

## Verification
The bench targets the edges of the length handling. A block count above the cap must be clipped to 32, or to 31 in a block process call; a design that skips the clip would overrun the data array or send the wrong count byte. A received block count of 40 must still be stored as-is while only 32 bytes are read. On the acknowledge side, a sequencer that NACKs the wrong byte, or NACKs the data byte before a checksum, would stop a real target early. For checksums, a corrupted CRC byte must give code 0x1F, and a design that failed to cover the repeated-start address byte would give it on good data too. Finally, a second protocol write during a transaction must not restart or retarget the sequence, and an address NACK must be told apart from a data NACK.

// File: rtl/smbus_seq.sv
module smbus_seq #(
  parameter int NBYTES = 32,
  parameter int AW     = $clog2(NBYTES + 8)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic [AW-1:0] reg_addr,
  input  logic [7:0]    reg_wdata,
  output logic [7:0]    reg_rdata,
  output logic          op_valid,
  output logic [1:0]    op_code,
  output logic [7:0]    op_data,
  output logic          op_nack,
  input  logic          rsp_valid,
  input  logic [7:0]    rsp_data,
  input  logic          rsp_nack
);
  localparam int AIW = $clog2(NBYTES);
  localparam logic [AW-1:0] A_PROT = AW'(0);
  localparam logic [AW-1:0] A_STAT = AW'(1);
  localparam logic [AW-1:0] A_ADDR = AW'(2);
  localparam logic [AW-1:0] A_CMD  = AW'(3);
  localparam int            DBASE  = 4;
  localparam logic [AW-1:0] A_BCNT = AW'(DBASE + NBYTES);
  localparam logic [AW-1:0] A_ALA  = AW'(DBASE + NBYTES + 1);
  localparam logic [AW-1:0] A_ALD0 = AW'(DBASE + NBYTES + 2);
  localparam logic [AW-1:0] A_ALD1 = AW'(DBASE + NBYTES + 3);
  localparam logic [7:0] CAP_FULL = 8'(NBYTES);
  localparam logic [7:0] CAP_LESS = 8'(NBYTES - 1);

  localparam logic [1:0] OP_START = 2'd0, OP_STOP = 2'd1, OP_WR = 2'd2, OP_RD = 2'd3;
  localparam logic [4:0] C_OK = 5'h00, C_DNAK = 5'h10, C_DERR = 5'h11,
                         C_UNSUP = 5'h19, C_PEC = 5'h1F;

  typedef enum logic [3:0] {
    PH_IDLE, PH_DEC, PH_START, PH_ADDR1, PH_CMD, PH_WCNT, PH_WDAT,
    PH_RS, PH_ADDR2, PH_RCNT, PH_RDAT, PH_PEC, PH_STOP
  } phase_t;

  phase_t      ph;
  logic [7:0]  prot, tgt, cmd, bcnt, ala, ald0, ald1, crc, idx;
  logic [7:0]  data [NBYTES];
  logic        done;
  logic [4:0]  code;

  function automatic logic [7:0] crc8(input logic [7:0] c, input logic [7:0] d);
    logic [7:0] x;
    x = c ^ d;
    for (int b = 0; b < 8; b++) x = x[7] ? ({x[6:0], 1'b0} ^ 8'h07) : {x[6:0], 1'b0};
    return x;
  endfunction

  // protocol decode
  logic       f_ok, f_rw1, f_cmd, f_wcnt, f_rs, f_rcnt, f_pec, rd_path;
  logic [7:0] wlen, rlen, c_full, c_less;
  wire        rdb = prot[0];

  assign c_full = (bcnt > CAP_FULL) ? CAP_FULL : bcnt;
  assign c_less = (bcnt > CAP_LESS) ? CAP_LESS : bcnt;

  always_comb begin
    f_ok = 1'b1; f_rw1 = 1'b0; f_cmd = 1'b0; f_wcnt = 1'b0; f_rs = 1'b0;
    f_rcnt = 1'b0; wlen = 8'd0; rlen = 8'd0; f_pec = prot[7];
    case (prot[6:1])
      6'h01: begin f_rw1 = rdb; f_pec = 1'b0; end
      6'h02: if (rdb) begin f_rw1 = 1'b1; rlen = 8'd1; end else f_cmd = 1'b1;
      6'h03: begin f_cmd = 1'b1; if (rdb) begin f_rs = 1'b1; rlen = 8'd1; end else wlen = 8'd1; end
      6'h04: begin f_cmd = 1'b1; if (rdb) begin f_rs = 1'b1; rlen = 8'd2; end else wlen = 8'd2; end
      6'h05: begin
        f_cmd = 1'b1;
        if (rdb) begin f_rs = 1'b1; f_rcnt = 1'b1; rlen = c_full; end
        else begin f_wcnt = 1'b1; wlen = c_full; end
      end
      6'h06: begin
        f_cmd = 1'b1; f_rs = 1'b1;
        if (rdb) begin f_wcnt = 1'b1; wlen = c_less; f_rcnt = 1'b1; rlen = c_full; end
        else begin wlen = 8'd2; rlen = 8'd2; end
      end
      6'h25: begin f_cmd = 1'b1; if (rdb) begin f_rs = 1'b1; rlen = c_full; end else wlen = c_full; end
      default: f_ok = 1'b0;
    endcase
  end
  assign rd_path = f_rs | f_rw1;

  // successor phases
  phase_t s_tail, s_rdat, s_afterw, s_aftercmd, s_after1;
  always_comb begin
    s_tail     = f_pec ? PH_PEC : PH_STOP;
    s_rdat     = (rlen != 8'd0) ? PH_RDAT : s_tail;
    s_afterw   = f_rs ? PH_RS : s_rdat;
    s_aftercmd = f_wcnt ? PH_WCNT : ((wlen != 8'd0) ? PH_WDAT : s_afterw);
    s_after1   = f_cmd ? PH_CMD : s_aftercmd;
  end

  // operation presented to the bus engine
  assign op_valid = (ph != PH_IDLE) && (ph != PH_DEC);
  always_comb begin
    op_code = OP_STOP; op_data = 8'd0; op_nack = 1'b0;
    case (ph)
      PH_START, PH_RS: op_code = OP_START;
      PH_ADDR1: begin op_code = OP_WR; op_data = {tgt[7:1], f_rw1}; end
      PH_ADDR2: begin op_code = OP_WR; op_data = {tgt[7:1], 1'b1}; end
      PH_CMD:   begin op_code = OP_WR; op_data = cmd; end
      PH_WCNT:  begin op_code = OP_WR; op_data = wlen; end
      PH_WDAT:  begin op_code = OP_WR; op_data = data[idx[AIW-1:0]]; end
      PH_RCNT:  op_code = OP_RD;
      PH_RDAT:  begin op_code = OP_RD; op_nack = (idx == rlen - 8'd1) && !f_pec; end
      PH_PEC:   if (rd_path) begin op_code = OP_RD; op_nack = 1'b1; end
                else begin op_code = OP_WR; op_data = crc; end
      default:  op_code = OP_STOP;
    endcase
  end

  wire [7:0] crc_nx = crc8(crc, (op_code == OP_RD) ? rsp_data : op_data);
  wire       take   = op_valid && rsp_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph <= PH_IDLE; prot <= '0; tgt <= '0; cmd <= '0; bcnt <= '0;
      ala <= '0; ald0 <= '0; ald1 <= '0; crc <= '0; idx <= '0;
      done <= 1'b0; code <= C_OK;
      for (int i = 0; i < NBYTES; i++) data[i] <= '0;
    end else begin
      if (reg_wr) begin
        if (reg_addr == A_PROT && ph == PH_IDLE) begin
          prot <= reg_wdata; done <= 1'b0; code <= C_OK;
          crc <= '0; idx <= '0; ph <= PH_DEC;
        end
        if (reg_addr == A_ADDR) tgt  <= reg_wdata;
        if (reg_addr == A_CMD)  cmd  <= reg_wdata;
        if (reg_addr == A_BCNT) bcnt <= reg_wdata;
        if (reg_addr == A_ALA)  ala  <= reg_wdata;
        if (reg_addr == A_ALD0) ald0 <= reg_wdata;
        if (reg_addr == A_ALD1) ald1 <= reg_wdata;
        for (int i = 0; i < NBYTES; i++)
          if (reg_addr == AW'(DBASE + i)) data[i] <= reg_wdata;
      end
      if (ph == PH_DEC) begin
        if (f_ok) ph <= PH_START;
        else begin code <= C_UNSUP; done <= 1'b1; ph <= PH_IDLE; end
      end else if (take) begin
        if (op_code == OP_WR || op_code == OP_RD) crc <= crc_nx;
        if (op_code == OP_WR && rsp_nack) begin
          code <= (ph == PH_ADDR1 || ph == PH_ADDR2) ? C_DNAK : C_DERR;
          idx  <= '0;
          ph   <= PH_STOP;
        end else begin
          case (ph)
            PH_START: ph <= PH_ADDR1;
            PH_RS:    ph <= PH_ADDR2;
            PH_ADDR1: ph <= s_after1;
            PH_CMD:   ph <= s_aftercmd;
            PH_WCNT:  ph <= (wlen != 8'd0) ? PH_WDAT : s_afterw;
            PH_WDAT: begin
              if (idx == wlen - 8'd1) begin idx <= '0; ph <= s_afterw; end
              else idx <= idx + 8'd1;
            end
            PH_ADDR2: ph <= f_rcnt ? PH_RCNT : s_rdat;
            PH_RCNT: begin
              bcnt <= rsp_data;
              ph   <= (rsp_data != 8'd0) ? PH_RDAT : s_tail;
            end
            PH_RDAT: begin
              data[idx[AIW-1:0]] <= rsp_data;
              if (idx == rlen - 8'd1) begin idx <= '0; ph <= s_tail; end
              else idx <= idx + 8'd1;
            end
            PH_PEC: begin
              if (rd_path && crc_nx != 8'd0) code <= C_PEC;
              ph <= PH_STOP;
            end
            PH_STOP: begin done <= 1'b1; ph <= PH_IDLE; end
            default: ph <= PH_IDLE;
          endcase
        end
      end
    end
  end

  always_comb begin
    reg_rdata = 8'd0;
    case (reg_addr)
      A_PROT: reg_rdata = prot;
      A_STAT: reg_rdata = {done, 2'b00, code};
      A_ADDR: reg_rdata = tgt;
      A_CMD:  reg_rdata = cmd;
      A_BCNT: reg_rdata = bcnt;
      A_ALA:  reg_rdata = ala;
      A_ALD0: reg_rdata = ald0;
      A_ALD1: reg_rdata = ald1;
      default: reg_rdata = 8'd0;
    endcase
    for (int i = 0; i < NBYTES; i++)
      if (reg_addr == AW'(DBASE + i)) reg_rdata = data[i];
  end

  // R3: a pending operation holds steady until answered
  p_op_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && !rsp_valid && !reg_wr) |=> (op_valid && $stable(op_code) && $stable(op_data) && $stable(op_nack)));

  p_first_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(op_valid) |-> (op_code == OP_START));

  p_nack_read_only_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code != OP_RD) |-> !op_nack);

  p_done_quiet_r13: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !op_valid);

  p_busy_ignore_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (ph != PH_IDLE && reg_wr && reg_addr == A_PROT) |=> $stable(prot));

  p_code_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (code == C_OK || code == C_DNAK || code == C_DERR || code == C_UNSUP || code == C_PEC));
endmodule

// File: tb/smbus_seq_tb.sv
module smbus_seq_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_wr = 1'b0;
  logic [5:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0, reg_rdata;
  logic op_valid, op_nack;
  logic [1:0] op_code;
  logic [7:0] op_data;
  logic rsp_valid = 1'b0, rsp_nack = 1'b0;
  logic [7:0] rsp_data = '0;

  smbus_seq dut_i (.clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .op_valid(op_valid), .op_code(op_code),
    .op_data(op_data), .op_nack(op_nack), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .rsp_nack(rsp_nack));

  always #4 clk = ~clk;

  int ncmp = 0, nerr = 0, k = 0, wcnt = 0, cyc = 0;
  logic [7:0] tcrc;
  logic [10:0] e_op [$];
  logic [8:0]  e_rsp [$];

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    ncmp++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] crc8(input logic [7:0] c, input logic [7:0] d);
    logic [7:0] x = c ^ d;
    for (int b = 0; b < 8; b++) x = x[7] ? ({x[6:0], 1'b0} ^ 8'h07) : {x[6:0], 1'b0};
    return x;
  endfunction

  // bus engine model: compares each requested operation with the expected list
  always @(negedge clk) begin
    cyc++;
    if (rsp_valid) begin rsp_valid = 1'b0; wcnt = 0; end
    else if (op_valid) begin
      if (wcnt >= (k % 3)) begin
        if (k < e_op.size()) begin
          check("R3 op", {op_code, op_data, op_nack}, e_op[k]);
          {rsp_nack, rsp_data} = e_rsp[k];
        end else begin
          check("R3 unexpected op", {op_code, op_data, op_nack}, 11'h7FF);
          {rsp_nack, rsp_data} = 9'h0;
        end
        rsp_valid = 1'b1; k++;
      end else wcnt++;
    end
  end

  task automatic begin_tx(); e_op.delete(); e_rsp.delete(); k = 0; tcrc = 8'h00; endtask
  task automatic p_start(); e_op.push_back({2'd0, 8'h00, 1'b0}); e_rsp.push_back(9'h0); endtask
  task automatic p_stop();  e_op.push_back({2'd1, 8'h00, 1'b0}); e_rsp.push_back(9'h0); endtask
  task automatic p_w(logic [7:0] d, logic nk = 1'b0);
    e_op.push_back({2'd2, d, 1'b0}); e_rsp.push_back({nk, 8'h00}); tcrc = crc8(tcrc, d);
  endtask
  task automatic p_r(logic [7:0] d, logic last);
    e_op.push_back({2'd3, 8'h00, last}); e_rsp.push_back({1'b0, d}); tcrc = crc8(tcrc, d);
  endtask
  task automatic p_pecw(); p_w(tcrc); endtask
  task automatic p_pecr(logic [7:0] corrupt); p_r(tcrc ^ corrupt, 1'b1); endtask

  task automatic wr(logic [5:0] a, logic [7:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask
  task automatic rd(logic [5:0] a, output logic [7:0] d);
    @(negedge clk); reg_addr = a; #1 d = reg_rdata;
  endtask

  task automatic go(logic [7:0] prot, logic [7:0] exp_stat, string req);
    logic [7:0] s;
    wr(6'h00, prot);
    s = 8'h00;
    for (int t = 0; t < 2000 && !s[7]; t++) rd(6'h01, s);
    check({req, " status"}, s, exp_stat);
    check({req, " all ops issued"}, k, e_op.size());
    check({req, " idle after"}, op_valid, 1'b0);
  endtask

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    rd(6'h01, v); check("R1 status", v, 8'h00);
    rd(6'h00, v); check("R1 protocol", v, 8'h00);
    rd(6'h24, v); check("R1 bcnt", v, 8'h00);
    check("R1 op_valid", op_valid, 1'b0);

    wr(6'h02, 8'hA1); // bit 0 set: must be replaced (R2)
    begin_tx(); p_start(); p_w(8'hA0); p_stop(); go(8'h02, 8'h80, "R2 quick write");
    begin_tx(); p_start(); p_w(8'hA1); p_stop(); go(8'h03, 8'h80, "R4 quick read");

    wr(6'h03, 8'h3C);
    begin_tx(); p_start(); p_w(8'hA0); p_w(8'h3C); p_pecw(); p_stop(); go(8'h84, 8'h80, "R9 byte write pec");

    begin_tx(); p_start(); p_w(8'hA1); p_r(8'h5A, 1'b1); p_stop(); go(8'h05, 8'h80, "R8 byte read");
    rd(6'h04, v); check("R4 byte read data", v, 8'h5A);

    wr(6'h04, 8'h11); wr(6'h05, 8'h22);
    begin_tx(); p_start(); p_w(8'hA0); p_w(8'h3C); p_w(8'h11); p_w(8'h22); p_stop(); go(8'h08, 8'h80, "R4 word write");

    begin_tx(); p_start(); p_w(8'hA0); p_w(8'h3C); p_start(); p_w(8'hA1);
    p_r(8'h34, 1'b0); p_r(8'h12, 1'b0); p_pecr(8'h00); p_stop(); go(8'h89, 8'h80, "R9 word read pec");
    rd(6'h04, v); check("R4 word low", v, 8'h34);
    rd(6'h05, v); check("R4 word high", v, 8'h12);

    begin_tx(); p_start(); p_w(8'hA0); p_w(8'h3C); p_start(); p_w(8'hA1);
    p_r(8'h34, 1'b0); p_r(8'h12, 1'b0); p_pecr(8'h40); p_stop(); go(8'h89, 8'h9F, "R9 pec mismatch");

    for (int i = 0; i < 32; i++) wr(6'(4 + i), 8'(i * 3 + 1));
    wr(6'h24, 8'd40);
    begin_tx(); p_start(); p_w(8'hA0); p_w(8'h3C); p_w(8'd32);
    for (int i = 0; i < 32; i++) p_w(8'(i * 3 + 1));
    p_stop(); go(8'h0A, 8'h80, "R5 block write cap 32");

    begin_tx(); p_start(); p_w(8'hA0); p_w(8'h3C); p_start(); p_w(8'hA1);
    p_r(8'd3, 1'b0); p_r(8'hC1, 1'b0); p_r(8'hC2, 1'b0); p_r(8'hC3, 1'b1); p_stop();
    go(8'h0B, 8'h80, "R6 block read");
    rd(6'h24, v); check("R6 count stored", v, 8'd3);
    rd(6'h06, v); check("R6 third byte", v, 8'hC3);

    begin_tx(); p_start(); p_w(8'hA0); p_w(8'h3C); p_start(); p_w(8'hA1); p_r(8'd40, 1'b0);
    for (int i = 0; i < 32; i++) p_r(8'(8'h80 + i), i == 31);
    p_stop(); go(8'h0B, 8'h80, "R6 block read cap");
    rd(6'h24, v); check("R6 raw count kept", v, 8'd40);
    rd(6'h23, v); check("R6 last byte", v, 8'h9F);

    wr(6'h04, 8'h55); wr(6'h05, 8'h66);
    begin_tx(); p_start(); p_w(8'hA0); p_w(8'h3C); p_w(8'h55); p_w(8'h66); p_start(); p_w(8'hA1);
    p_r(8'h77, 1'b0); p_r(8'h88, 1'b1); p_stop(); go(8'h0C, 8'h80, "R4 process call");
    rd(6'h05, v); check("R4 process call reply high", v, 8'h88);

    for (int i = 0; i < 32; i++) wr(6'(4 + i), 8'(8'hE0 ^ i));
    wr(6'h24, 8'd35);
    begin_tx(); p_start(); p_w(8'hA0); p_w(8'h3C); p_w(8'd31);
    for (int i = 0; i < 31; i++) p_w(8'(8'hE0 ^ i));
    p_start(); p_w(8'hA1); p_r(8'd2, 1'b0); p_r(8'hAB, 1'b0); p_r(8'hCD, 1'b0); p_pecr(8'h00); p_stop();
    go(8'h8D, 8'h80, "R5 block process call cap 31");
    rd(6'h24, v); check("R6 block process count", v, 8'd2);

    wr(6'h24, 8'd4);
    for (int i = 0; i < 4; i++) wr(6'(4 + i), 8'(8'h10 + i));
    begin_tx(); p_start(); p_w(8'hA0); p_w(8'h3C);
    for (int i = 0; i < 4; i++) p_w(8'(8'h10 + i));
    p_stop(); go(8'h4A, 8'h80, "R7 i2c block write");
    wr(6'h24, 8'd3);
    begin_tx(); p_start(); p_w(8'hA0); p_w(8'h3C); p_start(); p_w(8'hA1);
    p_r(8'h61, 1'b0); p_r(8'h62, 1'b0); p_r(8'h63, 1'b1); p_stop(); go(8'h4B, 8'h80, "R7 i2c block read");
    rd(6'h24, v); check("R7 length unchanged", v, 8'd3);

    begin_tx(); p_start(); p_w(8'hA0, 1'b1); p_stop(); go(8'h08, 8'h90, "R10 address nack");
    wr(6'h04, 8'h11);
    begin_tx(); p_start(); p_w(8'hA0); p_w(8'h3C); p_w(8'h11, 1'b1); p_stop(); go(8'h08, 8'h91, "R10 data nack");

    begin_tx(); go(8'h10, 8'h99, "R11 unsupported form");

    // R12: second protocol write while running
    begin_tx(); p_start(); p_w(8'hA0); p_stop();
    wr(6'h00, 8'h02); wr(6'h00, 8'h0B);
    v = 8'h00;
    for (int t = 0; t < 2000 && !v[7]; t++) rd(6'h01, v);
    repeat (20) @(negedge clk);
    check("R12 status", v, 8'h80);
    check("R12 op count", k, 3);
    rd(6'h00, v); check("R12 protocol kept", v, 8'h02);
    check("R12 idle", op_valid, 1'b0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", ncmp, nerr);
    $finish;
  end

  initial begin
    wait (cyc > 150000);
    ncmp++; nerr++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", ncmp, nerr);
    $finish;
  end
endmodule